// File: doc/BRIEF.md
# Dual-Halfword Saturation Unit

This block takes a 32-bit word holding two signed 16-bit halves and clamps each half, on its own, into a range chosen by a single 4-bit width code. The width code means different things in the two modes. In signed mode a code of k gives a (k+1)-bit two's complement range. In unsigned mode a code of k gives a k-bit range that starts at zero. The packed result and a saturation indication are produced combinationally in the same cycle the operand is presented.

Whenever a valid operation clamps either half, a sticky saturation flag is set on the next clock edge. The flag is held until reset or until the explicit clear input is used. An execution pipeline would present one operation per cycle with `opValid` and read `result` in that same cycle. Software reads and clears the sticky flag through the same pipeline.

Top module: `halfsat_top`

## Requirements
- R1: With `isUnsigned`=0 and width code k (0..15), each half is clamped to the range -(2^k) to 2^k-1, which is a (k+1)-bit signed range.
- R2: With `isUnsigned`=1 and width code k (0..15), each half is clamped to the range 0 to 2^k-1. A negative half gives 0.
- R3: Each half is read as a signed 16-bit value and saturated independently. The low input half produces `result[15:0]` and the high input half produces `result[31:16]`.
- R4: A half already inside the range selected by the mode and width code appears unchanged at its position in `result`.
- R5: `satPulse` is 1 in the same cycle exactly when `opValid` is 1 and at least one half is clamped to either bound.
- R6: `qFlag` becomes 1 on the clock edge that samples `satPulse`=1. Later operations that do not clamp leave it at 1.
- R7: `qClear`=1 clears `qFlag` on the next edge. When `qClear` and `satPulse` are both 1 in the same cycle, the set wins and `qFlag` becomes 1.
- R8: While `rstN` is 0, `qFlag` is 0.
- R9: In unsigned mode with width code 0, both result halves are 0, and any nonzero half raises `satPulse`.
- R10: With `opValid`=0, `satPulse` stays 0 and `qFlag` keeps its value, whatever the operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the sticky flag |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | An operation is presented this cycle |
| operand | input | 32 | Two packed signed halves |
| widthCode | input | 4 | Saturation width code |
| isUnsigned | input | 1 | 1 selects unsigned clamping, 0 selects signed clamping |
| qClear | input | 1 | Clears the sticky flag |
| result | output | 32 | Packed saturated halves |
| satPulse | output | 1 | This operation clamped at least one half |
| qFlag | output | 1 | Sticky saturation flag |

## Verification
Every width code is tried in both modes. For each bound, one half is driven exactly at the bound, one step inside it and one step outside it. This separates an off-by-one in the range from a wrong mode decode, because only the value outside the bound may change and pulse. The halves carry different values in the same operation, which exposes swapped or shared lanes. Separate sequences cover the zero-width unsigned case with zero and nonzero halves, sticky hold across clean operations, clear alone, clear together with a saturating operation, and idle cycles with out-of-range operands.

// File: rtl/halfsat_pkg.sv
package halfsat_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic evalEn;
    logic setQ;
    logic clrQ;
  } satStrobe_t;
endpackage

// File: rtl/halfsat_lane.sv
module halfsat_lane #(
  parameter int HALF_W = 16,
  localparam int CODE_W = $clog2(HALF_W)
) (
  input  logic [HALF_W-1:0] halfIn,
  input  logic [CODE_W-1:0] widthCode,
  input  logic              isUnsigned,
  output logic [HALF_W-1:0] halfOut,
  output logic              clampHigh,
  output logic              clampLow
);
  localparam int EXT_W = HALF_W + 1;

  logic [EXT_W-1:0]        stepPow;
  logic signed [EXT_W-1:0] upperBound;
  logic signed [EXT_W-1:0] lowerBound;
  logic signed [EXT_W-1:0] extIn;

  always_comb begin
    stepPow    = {{(EXT_W-1){1'b0}}, 1'b1} << widthCode;
    // both modes share the upper bound 2^k-1
    upperBound = $signed(stepPow - {{(EXT_W-1){1'b0}}, 1'b1});
    lowerBound = isUnsigned ? '0 : -$signed(stepPow);
    extIn      = $signed({halfIn[HALF_W-1], halfIn});
    clampHigh  = extIn > upperBound;
    clampLow   = extIn < lowerBound;
    if (clampHigh)     halfOut = upperBound[HALF_W-1:0];
    else if (clampLow) halfOut = lowerBound[HALF_W-1:0];
    else               halfOut = halfIn;
  end
endmodule

// File: rtl/halfsat_ctrl.sv
module halfsat_ctrl
  import halfsat_pkg::*;
(
  input  logic       opValid,
  input  logic       qClear,
  input  logic       anyClamp,
  output satStrobe_t strobe
);
  always_comb begin
    strobe.evalEn = opValid;
    strobe.setQ   = opValid & anyClamp;
    strobe.clrQ   = qClear;
  end
endmodule

// File: rtl/halfsat_datapath.sv
module halfsat_datapath
  import halfsat_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int LANES  = 2,
  localparam int CODE_W = $clog2(HALF_W),
  localparam int WORD_W = HALF_W * LANES
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] operand,
  input  logic [CODE_W-1:0] widthCode,
  input  logic              isUnsigned,
  input  satStrobe_t        strobe,
  output logic [WORD_W-1:0] result,
  output logic              anyClamp,
  output logic              qFlag
);
  logic [LANES-1:0] hiHit;
  logic [LANES-1:0] loHit;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    halfsat_lane #(.HALF_W(HALF_W)) lane_i (
      .halfIn    (operand[g*HALF_W +: HALF_W]),
      .widthCode (widthCode),
      .isUnsigned(isUnsigned),
      .halfOut   (result[g*HALF_W +: HALF_W]),
      .clampHigh (hiHit[g]),
      .clampLow  (loHit[g])
    );
  end

  assign anyClamp = |(hiHit | loHit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              qFlag <= 1'b0;
    else if (strobe.setQ)   qFlag <= 1'b1;
    else if (strobe.clrQ)   qFlag <= 1'b0;
  end

  // R6
  q_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setQ |=> qFlag);
  // R6
  q_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (qFlag && !strobe.clrQ) |=> qFlag);
  // R7
  q_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrQ && !strobe.setQ) |=> !qFlag);
  // R10
  q_rise_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!qFlag && !strobe.setQ) |=> !qFlag);
  // R4
  pass_through_chk: assert property (@(posedge clk) disable iff (!rstN)
    !anyClamp |-> result == operand);
  // R9
  zero_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isUnsigned && widthCode == '0) |-> result == '0);
endmodule

// File: rtl/halfsat_top.sv
module halfsat_top
  import halfsat_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int LANES  = 2,
  localparam int CODE_W = $clog2(HALF_W),
  localparam int WORD_W = HALF_W * LANES
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [WORD_W-1:0] operand,
  input  logic [CODE_W-1:0] widthCode,
  input  logic              isUnsigned,
  input  logic              qClear,
  output logic [WORD_W-1:0] result,
  output logic              satPulse,
  output logic              qFlag
);
  satStrobe_t strobe;
  logic       anyClamp;

  halfsat_ctrl ctrl_i (
    .opValid (opValid),
    .qClear  (qClear),
    .anyClamp(anyClamp),
    .strobe  (strobe)
  );

  halfsat_datapath #(.HALF_W(HALF_W), .LANES(LANES)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .operand   (operand),
    .widthCode (widthCode),
    .isUnsigned(isUnsigned),
    .strobe    (strobe),
    .result    (result),
    .anyClamp  (anyClamp),
    .qFlag     (qFlag)
  );

  assign satPulse = strobe.setQ;

  // R5
  pulse_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |-> !satPulse);
  // R8
  reset_flag_chk: assert property (@(posedge clk)
    !rstN |-> !qFlag);
endmodule

// File: tb/halfsat_top_tb_top.sv
module halfsat_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [31:0] operand = '0;
  logic [3:0]  widthCode = '0;
  logic        isUnsigned = 1'b0;
  logic        qClear = 1'b0;
  logic [31:0] result;
  logic        satPulse;
  logic        qFlag;

  int errCount = 0;
  int chkCount = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  halfsat_top dut_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .operand(operand),
    .widthCode(widthCode), .isUnsigned(isUnsigned), .qClear(qClear),
    .result(result), .satPulse(satPulse), .qFlag(qFlag)
  );

  task automatic check(string req, longint act, longint expv);
    chkCount++;
    if (act != expv) begin
      errCount++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // model from R1/R2: bounds -(2^k)..2^k-1 signed, 0..2^k-1 unsigned
  function automatic int clampModel(int v, int k, bit uns, output bit hit);
    int hi = (1 << k) - 1;
    int lo = uns ? 0 : -(1 << k);
    hit = 1'b0;
    if (v > hi) begin hit = 1'b1; return hi; end
    if (v < lo) begin hit = 1'b1; return lo; end
    return v;
  endfunction

  // one op with given flags; checks result and pulse, then flag after the edge
  task automatic runOp(string req, int loV, int hiV, int k, bit uns, bit clr,
                       bit valid, bit expQ);
    bit hitL, hitH;
    int eL, eH;
    @(negedge clk);
    operand    = {hiV[15:0], loV[15:0]};
    widthCode  = k[3:0];
    isUnsigned = uns;
    qClear     = clr;
    opValid    = valid;
    eL = clampModel(loV, k, uns, hitL);
    eH = clampModel(hiV, k, uns, hitH);
    #1;
    if (valid) begin
      check({req, " result"}, result, {eH[15:0], eL[15:0]});
      check({req, " satPulse"}, satPulse, (hitL | hitH));
    end else begin
      check({req, " satPulse idle"}, satPulse, 0);
    end
    @(negedge clk);
    check({req, " qFlag"}, qFlag, expQ);
    opValid = 1'b0;
    qClear  = 1'b0;
  endtask

  task automatic testReset();
    check("R8 qFlag in reset", qFlag, 0);
  endtask

  // R1 R2 R3 R4 R5 R6: every code, both modes, around each bound
  task automatic testSweep();
    for (int m = 0; m < 2; m++) begin
      for (int k = 0; k < 16; k++) begin
        int hi = (1 << k) - 1;
        int lo = (m == 1) ? 0 : -(1 << k);
        int pts[6];
        pts = '{hi - 1, hi, hi + 1, lo - 1, lo, lo + 1};
        for (int i = 0; i < 6; i++) begin
          int a = pts[i];
          int b = pts[5 - i];
          bit hA, hB;
          int d;
          if (a > 32767 || a < -32768 || b > 32767 || b < -32768) continue;
          d = clampModel(a, k, m[0], hA);
          d = clampModel(b, k, m[0], hB);
          // clear together with the op: flag follows this op alone (R7)
          runOp(m ? "R2 sweep" : "R1 sweep", a, b, k, m[0], 1'b1, 1'b1, hA | hB);
        end
      end
    end
  endtask

  // R3: low half clamps, high passes, and the reverse
  task automatic testIndependent();
    runOp("R3 low clamps", 300, -5, 7, 1'b0, 1'b1, 1'b1, 1'b1);
    runOp("R3 high clamps", 12, -700, 8, 1'b0, 1'b1, 1'b1, 1'b1);
    runOp("R4 both inside", 1234, -1234, 14, 1'b0, 1'b1, 1'b1, 1'b0);
  endtask

  // R6: flag held across clean operations
  task automatic testSticky();
    runOp("R6 set", 5000, 0, 3, 1'b1, 1'b0, 1'b1, 1'b1);
    runOp("R6 hold 1", 1, 2, 15, 1'b0, 1'b0, 1'b1, 1'b1);
    runOp("R6 hold 2", 0, 0, 0, 1'b0, 1'b0, 1'b1, 1'b1);
  endtask

  // R7: clear alone, then clear with a saturating op
  task automatic testClear();
    runOp("R7 clear alone", 0, 0, 4, 1'b0, 1'b1, 1'b0, 1'b0);
    runOp("R7 set", -9, 0, 2, 1'b1, 1'b0, 1'b1, 1'b1);
    runOp("R7 set wins", 100, 0, 1, 1'b0, 1'b1, 1'b1, 1'b1);
  endtask

  // R9: unsigned width zero
  task automatic testZeroWidth();
    runOp("R9 zero halves", 0, 0, 0, 1'b1, 1'b1, 1'b1, 1'b0);
    runOp("R9 low one", 1, 0, 0, 1'b1, 1'b1, 1'b1, 1'b1);
    runOp("R9 high neg", 0, -1, 0, 1'b1, 1'b1, 1'b1, 1'b1);
  endtask

  // R10: idle cycles with out-of-range operands leave the flag alone
  task automatic testIdle();
    runOp("R10 clear first", 0, 0, 0, 1'b0, 1'b1, 1'b0, 1'b0);
    runOp("R10 idle low", 32767, -32768, 0, 1'b0, 1'b0, 1'b0, 1'b0);
    runOp("R10 set", 32767, 0, 0, 1'b0, 1'b0, 1'b1, 1'b1);
    runOp("R10 idle high", 32767, -32768, 0, 1'b1, 1'b0, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    check("R8 qFlag after reset", qFlag, 0);
    testSweep();
    testIndependent();
    testSticky();
    testClear();
    testZeroWidth();
    testIdle();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errCount, chkCount);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      chkCount++;
      errCount++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errCount, chkCount);
      $finish;
    end
  end
endmodule